// File: doc/BRIEF.md
# Host Byte Receiver for a Compatibility-Mode Parallel Port

This block sits behind the pins of an IEEE 1284 parallel port and takes in bytes that the host sends in compatibility mode. The host puts a byte on the eight data lines and pulls the active-low strobe low. The block brings the strobe, the data and the other host control lines into the system clock domain through a synchroniser chain. On the synchronised falling edge of the strobe it latches the byte and raises BUSY in that same clock edge. It then writes the byte into a small receive FIFO and sends an active-low acknowledge pulse. BUSY drops on the same edge that ends the acknowledge pulse.

When the FIFO is full, the byte waits in the latch. BUSY stays high and no acknowledge is sent until the reading logic frees a slot. The host's active-low initialise line empties the FIFO and returns the handshake to idle. Logic inside the chip reads the FIFO through a valid/ready pair. Three status pins to the host (paper-out, online and an active-low error) follow register inputs. The select-in and auto-feed requests from the host come out synchronised and active high.

Top module: `host_byte_rx`

## Requirements
- R1: A byte on `hostData` that is stable while `hostStrobeN` falls is captured. After passing through the FIFO it appears unchanged on `rxData`.
- R2: `busy` rises on the clock edge that captures the byte. With the default two synchroniser stages, this is the third rising clock edge after `hostStrobeN` goes low.
- R3: If the FIFO has room, the captured byte is written on the next clock edge after capture. `ackN` goes low on that same edge.
- R4: `ackN` stays low for exactly `ACK_W` clock cycles, and `busy` is high throughout. `busy` returns to 0 on the same edge at which `ackN` returns to 1.
- R5: If the FIFO is full when a byte is captured, `busy` stays high and `ackN` stays high until a read frees a slot. The byte is then written and acknowledged as in R3 and R4.
- R6: The FIFO holds `DEPTH` bytes (a power of two). It returns bytes in arrival order. `rxValid` is high while it is not empty, and a byte is removed on each clock edge where `rxValid` and `rxReady` are both 1.
- R7: `paperOut` follows `paperOutReg` and `online` follows `onlineReg`. `errorN` is the inverse of `errorReg`. Each output follows its input one clock after the input changes.
- R8: While the synchronised `hostInitN` is low, the FIFO is emptied, `busy` is held at 0 and `ackN` at 1, and strobe edges are ignored. No byte offered during that time reaches `rxData`.
- R9: `selectReq` and `autoFeedReq` are the synchronised inverses of `hostSelInN` and `hostAutoFdN`.
- R10: A strobe falling edge that arrives while `busy` is high does not capture a byte. Only the byte latched first is written and acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostData | input | DATA_W | Data lines from the host |
| hostStrobeN | input | 1 | Host strobe, active low |
| hostInitN | input | 1 | Host initialise request, active low |
| hostSelInN | input | 1 | Host select-in, active low |
| hostAutoFdN | input | 1 | Host auto-feed, active low |
| paperOutReg | input | 1 | Register value for the paper-out pin |
| onlineReg | input | 1 | Register value for the online pin |
| errorReg | input | 1 | Register value for the error condition |
| busy | output | 1 | Busy to host, active high |
| ackN | output | 1 | Acknowledge pulse to host, active low |
| paperOut | output | 1 | Paper-out status to host, active high |
| online | output | 1 | Select status to host, active high |
| errorN | output | 1 | Fault status to host, active low |
| selectReq | output | 1 | Synchronised select-in request, active high |
| autoFeedReq | output | 1 | Synchronised auto-feed request, active high |
| rxData | output | DATA_W | FIFO head byte |
| rxValid | output | 1 | FIFO head byte valid |
| rxReady | input | 1 | Internal reader accepts the head byte |

## Verification
The assertions check the handshake ordering on every cycle. They check that each rise of BUSY follows a detected strobe edge, that a capture with FIFO space leads to ACK on the next cycle, that ACK is low only while BUSY is high, that the pulse lasts exactly `ACK_W` cycles and that BUSY only falls as ACK rises. They also check that ACK is held off while the FIFO is full, that the FIFO never takes a write when full, and that initialise empties the FIFO. Only the bench scenarios can show some results. These are the exact cycle count from the strobe pin to BUSY, the byte values and their order through the FIFO, the status pin mapping, and the loss of strobes sent during BUSY or initialise.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;  // latch the synchronised data byte
    logic push;     // write the latched byte into the FIFO
    logic flush;    // empty the FIFO
  } hbr_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STORE = 2'd1,
    ST_ACK   = 2'd2
  } hbr_state_t;
endpackage

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
  import hbr_pkg::*;
#(
  parameter int ACK_W = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     strbFall,
  input  logic     initActive,
  input  logic     fifoFull,
  output logic     busy,
  output logic     ackN,
  output hbr_ctl_t ctl
);
  localparam int CW = $clog2(ACK_W + 1);

  hbr_state_t      state;
  logic [CW-1:0]   ackCnt;

  always_comb begin
    ctl.capture = (state == ST_IDLE) && strbFall && !initActive;
    ctl.push    = (state == ST_STORE) && !fifoFull && !initActive;
    ctl.flush   = initActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      ackN   <= 1'b1;
      ackCnt <= '0;
    end else if (initActive) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      ackN   <= 1'b1;
      ackCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strbFall) begin
            busy  <= 1'b1;
            state <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (!fifoFull) begin
            ackN   <= 1'b0;
            ackCnt <= CW'(ACK_W - 1);
            state  <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (ackCnt == '0) begin
            ackN  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end else begin
            ackCnt <= ackCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hbr_dpath.sv
module hbr_dpath
  import hbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostStrobeN,
  input  logic              hostInitN,
  input  logic              hostSelInN,
  input  logic              hostAutoFdN,
  input  logic              paperOutReg,
  input  logic              onlineReg,
  input  logic              errorReg,
  input  hbr_ctl_t          ctl,
  output logic              strbFall,
  output logic              initActive,
  output logic              fifoFull,
  output logic              paperOut,
  output logic              online,
  output logic              errorN,
  output logic              selectReq,
  output logic              autoFeedReq,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady
);
  localparam int SW = DATA_W + 4;
  localparam int AW = $clog2(DEPTH);
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {DATA_W{1'b0}}};

  // Synchroniser chain: {strobeN, initN, selInN, autoFdN, data}
  logic [SYNC_N-1:0][SW-1:0] syncChain;
  logic [SW-1:0]             syncOut;
  logic                      strbSync, strbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_N; i++) syncChain[i] <= SYNC_RST;
    end else begin
      syncChain[0] <= {hostStrobeN, hostInitN, hostSelInN, hostAutoFdN, hostData};
      for (int i = 1; i < SYNC_N; i++) syncChain[i] <= syncChain[i-1];
    end
  end

  assign syncOut     = syncChain[SYNC_N-1];
  assign strbSync    = syncOut[SW-1];
  assign initActive  = ~syncOut[SW-2];
  assign selectReq   = ~syncOut[SW-3];
  assign autoFeedReq = ~syncOut[SW-4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strbPrev <= 1'b1;
    else       strbPrev <= strbSync;
  end
  assign strbFall = strbPrev & ~strbSync;

  // Byte latch
  logic [DATA_W-1:0] byteReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            byteReg <= '0;
    else if (ctl.capture) byteReg <= syncOut[DATA_W-1:0];
  end

  // Status pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paperOut <= 1'b0;
      online   <= 1'b0;
      errorN   <= 1'b1;
    end else begin
      paperOut <= paperOutReg;
      online   <= onlineReg;
      errorN   <= ~errorReg;
    end
  end

  // Receive FIFO
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wrPtr, rdPtr;
  logic              pop;

  assign fifoFull = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign rxValid  = (wrPtr != rdPtr);
  assign rxData   = mem[rdPtr[AW-1:0]];
  assign pop      = rxValid && rxReady && !ctl.flush;

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr[AW-1:0]] <= byteReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (pop)      rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/host_byte_rx.sv
module host_byte_rx
  import hbr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int ACK_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostStrobeN,
  input  logic              hostInitN,
  input  logic              hostSelInN,
  input  logic              hostAutoFdN,
  input  logic              paperOutReg,
  input  logic              onlineReg,
  input  logic              errorReg,
  output logic              busy,
  output logic              ackN,
  output logic              paperOut,
  output logic              online,
  output logic              errorN,
  output logic              selectReq,
  output logic              autoFeedReq,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady
);
  hbr_ctl_t ctl;
  logic     strbFall, initActive, fifoFull;

  hbr_ctrl #(.ACK_W(ACK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strbFall(strbFall), .initActive(initActive),
    .fifoFull(fifoFull), .busy(busy), .ackN(ackN), .ctl(ctl)
  );

  hbr_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_N(SYNC_N)) u_dpath (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostStrobeN(hostStrobeN),
    .hostInitN(hostInitN), .hostSelInN(hostSelInN), .hostAutoFdN(hostAutoFdN),
    .paperOutReg(paperOutReg), .onlineReg(onlineReg), .errorReg(errorReg),
    .ctl(ctl), .strbFall(strbFall), .initActive(initActive), .fifoFull(fifoFull),
    .paperOut(paperOut), .online(online), .errorN(errorN),
    .selectReq(selectReq), .autoFeedReq(autoFeedReq),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady)
  );
endmodule

// File: rtl/hbr_checker.sv
module hbr_checker
  import hbr_pkg::*;
#(
  parameter int ACK_W = 4
) (
  input logic     clk,
  input logic     rstN,
  input logic     busy,
  input logic     ackN,
  input logic     rxValid,
  input logic     strbFall,
  input logic     fifoFull,
  input logic     initActive,
  input hbr_ctl_t ctl
);
  localparam int CW = $clog2(ACK_W + 2) + 1;
  logic [CW-1:0] ackLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ackLowCnt <= '0;
    else if (!ackN) ackLowCnt <= ackLowCnt + 1'b1;
    else            ackLowCnt <= '0;
  end

  assert_busy_on_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strbFall));

  assert_store_bounded_R3: assert property (@(posedge clk) disable iff (!rstN || initActive)
    ($rose(busy) && !fifoFull) |=> !ackN);

  assert_ack_inside_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> busy);

  assert_ack_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackN) && !$past(initActive)) |-> (ackLowCnt == CW'(ACK_W)));

  assert_busy_ends_with_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($rose(ackN) || $past(initActive)));

  assert_hold_when_full_R5: assert property (@(posedge clk) disable iff (!rstN || initActive)
    (busy && ackN && fifoFull) |=> ackN);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> !fifoFull);

  assert_init_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    initActive |=> (!rxValid && !busy));
endmodule

bind host_byte_rx hbr_checker #(.ACK_W(ACK_W)) u_hbr_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .ackN(ackN), .rxValid(rxValid),
  .strbFall(strbFall), .fifoFull(fifoFull), .initActive(initActive), .ctl(ctl)
);

// File: tb/test_host_byte_rx.sv
module test_host_byte_rx;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int ACK_W  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic              rstN;
  logic [DATA_W-1:0] hostData;
  logic              hostStrobeN, hostInitN, hostSelInN, hostAutoFdN;
  logic              paperOutReg, onlineReg, errorReg, rxReady;
  logic              busy, ackN, paperOut, online, errorN, selectReq, autoFeedReq;
  logic [DATA_W-1:0] rxData;
  logic              rxValid;

  host_byte_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ACK_W(ACK_W)) i_host_byte_rx (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostStrobeN(hostStrobeN),
    .hostInitN(hostInitN), .hostSelInN(hostSelInN), .hostAutoFdN(hostAutoFdN),
    .paperOutReg(paperOutReg), .onlineReg(onlineReg), .errorReg(errorReg),
    .busy(busy), .ackN(ackN), .paperOut(paperOut), .online(online), .errorN(errorN),
    .selectReq(selectReq), .autoFeedReq(autoFeedReq),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DATA_W-1:0] expQ[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Monitor: compare every byte popped by the internal reader (R1, R6, R10)
  always @(negedge clk) begin
    if (rstN && rxValid && rxReady) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected byte actual %0h expected none", rxData);
      end else begin
        check("R1/R6 byte order", {24'd0, rxData}, {24'd0, expQ.pop_front()});
      end
    end
  end

  task automatic strobePulse(input logic [DATA_W-1:0] b);
    tick(); hostData = b;
    tick(); hostStrobeN = 1'b0;
    repeat (4) @(negedge clk);
    tick(); hostStrobeN = 1'b1;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy && ackN) break;
    end
  endtask

  task automatic sendByte(input logic [DATA_W-1:0] b);
    expQ.push_back(b);
    strobePulse(b);
    waitIdle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hostData = '0; hostStrobeN = 1'b1; hostInitN = 1'b1;
    hostSelInN = 1'b1; hostAutoFdN = 1'b1; paperOutReg = 1'b0; onlineReg = 1'b0;
    errorReg = 1'b0; rxReady = 1'b1;
    repeat (4) tick();
    rstN = 1'b1;
    @(negedge clk);
    check("reset busy", busy, 0);
    check("reset ackN", ackN, 1);
    check("reset rxValid", rxValid, 0);

    // R7 status pins
    tick(); paperOutReg = 1'b1; onlineReg = 1'b1; errorReg = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R7 paperOut", paperOut, 1);
    check("R7 online", online, 1);
    check("R7 errorN", errorN, 0);
    tick(); errorReg = 1'b0; onlineReg = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R7 errorN released", errorN, 1);
    check("R7 online low", online, 0);

    // R9 select-in / auto-feed
    tick(); hostSelInN = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 selectReq", selectReq, 1);
    check("R9 autoFeedReq idle", autoFeedReq, 0);
    tick(); hostSelInN = 1'b1; hostAutoFdN = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 selectReq off", selectReq, 0);
    check("R9 autoFeedReq", autoFeedReq, 1);
    tick(); hostAutoFdN = 1'b1;

    // R2/R3/R4 exact timing
    begin
      int lowCnt;
      expQ.push_back(8'hA5);
      tick(); hostData = 8'hA5;
      tick(); hostStrobeN = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 busy before capture", busy, 0);
      @(negedge clk);
      check("R2 busy at capture", busy, 1);
      check("R3 ackN not yet", ackN, 1);
      @(negedge clk);
      check("R3 ackN after store", ackN, 0);
      hostStrobeN = 1'b1;
      lowCnt = 1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (ackN) break;
        check("R4 busy during ack", busy, 1);
        lowCnt++;
      end
      check("R4 ack width", lowCnt, ACK_W);
      check("R4 busy falls with ack", busy, 0);
    end

    // R1 several patterns
    sendByte(8'h00);
    sendByte(8'hFF);
    sendByte(8'h3C);
    sendByte(8'h81);
    repeat (4) @(negedge clk);
    check("R1 queue drained", expQ.size(), 0);

    // R5/R10 back-pressure
    tick(); rxReady = 1'b0;
    for (int i = 0; i < DEPTH; i++) sendByte(8'(8'h10 + i));
    expQ.push_back(8'hEE);
    strobePulse(8'hEE);
    repeat (20) @(negedge clk);
    check("R5 busy held when full", busy, 1);
    check("R5 no ack when full", ackN, 1);
    strobePulse(8'h77);  // R10: falls while busy, must be dropped
    repeat (10) @(negedge clk);
    check("R10 still held", busy, 1);
    tick(); rxReady = 1'b1;
    waitIdle();
    repeat (DEPTH + 10) @(negedge clk);
    check("R5 pending byte delivered", expQ.size(), 0);
    check("R10 no extra byte", rxValid, 0);

    // R8 initialise
    tick(); rxReady = 1'b0;
    sendByte(8'h5A);
    sendByte(8'hC3);
    tick(); hostInitN = 1'b0;
    repeat (4) @(negedge clk);
    strobePulse(8'h99);
    repeat (3) @(negedge clk);
    check("R8 fifo empty in init", rxValid, 0);
    check("R8 busy clear in init", busy, 0);
    tick(); hostInitN = 1'b1;
    expQ.delete();
    repeat (8) @(negedge clk);
    check("R8 no byte after init", rxValid, 0);
    check("R8 ackN idle", ackN, 1);
    tick(); rxReady = 1'b1;
    sendByte(8'h42);
    repeat (4) @(negedge clk);
    check("R8 recovered", expQ.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule